// File: doc/BRIEF.md
# Element-Width Packed Register File

This block holds a bank of 64-bit rows that can also be treated as one flat array of narrower elements. Each access picks an element width of 8, 16, 32 or 64 bits and names an element by a base row plus an element offset. The offset is split into a row step and a lane inside the row. The row step is the offset divided by the number of elements that fit in 64 bits. The lane is the remainder. With the 64-bit width, the block reads and writes whole rows.

There is one combinational read port and one write port. The write port commits at the rising clock edge. A read returns the selected lane, zero-extended to 64 bits. A write replaces only its lane and keeps every other bit of the row. A read that hits the row being written in the same cycle sees the merged result. An access whose computed row lies past the last row raises a per-port out-of-range flag. Such a write is dropped, and such a read returns zero.

Top module: `ewRegFile`

## Requirements
- R1: After reset every row reads as zero.
- R2: Width code 00 selects 64-bit elements. The row is base plus offset, and the whole row is read or written.
- R3: Width code 01 selects 32-bit elements, 10 selects 16-bit elements and 11 selects 8-bit elements. The row is base plus offset divided by (64 / width). The lane is offset modulo (64 / width). The lane occupies bits starting at lane × width.
- R4: A narrow read returns the selected lane in the low bits of rdData, with all higher bits zero.
- R5: A narrow write changes only the selected lane. All other lanes of that row keep their previous values.
- R6: Bits of wrData above the selected element width have no effect on the stored row.
- R7: Element offsets that run past the last lane of a row continue at lane 0 of the following rows.
- R8: When the computed row exceeds ROWS-1, the port's out-of-range flag is 1. An out-of-range write changes no row, and an out-of-range read returns zero. A computed row of exactly ROWS-1 is in range.
- R9: A read whose row equals the row being written in the same cycle returns data that includes that write.
- R10: With wrEn low, the write inputs change no stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset, clears all rows |
| wrEn | input | 1 | Write request |
| wrBase | input | ROW_AW (7) | Write base row |
| wrOffs | input | OFFS_W (10) | Write element offset |
| wrWidth | input | 2 | Write element width code (00=64, 01=32, 10=16, 11=8) |
| wrData | input | 64 | Write value; only the low element-width bits are used |
| wrOor | output | 1 | Write address is past the last row |
| rdBase | input | ROW_AW (7) | Read base row |
| rdOffs | input | OFFS_W (10) | Read element offset |
| rdWidth | input | 2 | Read element width code |
| rdData | output | 64 | Selected element, zero-extended |
| rdOor | output | 1 | Read address is past the last row |

## Verification
A wrong lane shift or mask shows up as soon as a later read of the same row, or a neighbouring lane, returns the wrong value. So every narrow write is followed by full-row reads and cross-width reads of adjacent lanes. A row-step error (wrap or out-of-range) lands data in the wrong row. The bench catches it by reading the intended row and the rows on either side, including the row that a truncated out-of-range address would alias to. A broken forward path is visible only in the cycle of the write, so the bench samples rdData between the edges while the write is pending.

// File: rtl/ewrf_pkg.sv
package ewrf_pkg;

  localparam int ROW_W = 64;

  typedef enum logic [1:0] {
    EW64 = 2'b00,
    EW32 = 2'b01,
    EW16 = 2'b10,
    EW8  = 2'b11
  } ewSel_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic   wrCommit;
    logic   fwdHit;
    logic   rdValid;
    logic   rdFull;
    logic   wrFull;
    ewSel_e rdW;
    ewSel_e wrW;
    logic [5:0] rdShift;
    logic [5:0] wrShift;
  } ctrlStrb_t;

  // element-width mask, unshifted
  function automatic logic [ROW_W-1:0] laneMask(ewSel_e w);
    case (w)
      EW32:    laneMask = 64'h0000_0000_FFFF_FFFF;
      EW16:    laneMask = 64'h0000_0000_0000_FFFF;
      EW8:     laneMask = 64'h0000_0000_0000_00FF;
      default: laneMask = '1;
    endcase
  endfunction

  // bit position of a lane: lane times element width
  function automatic logic [5:0] laneShift(ewSel_e w, logic [2:0] offsLow);
    case (w)
      EW32:    laneShift = {offsLow[0], 5'b0};
      EW16:    laneShift = {offsLow[1:0], 4'b0};
      EW8:     laneShift = {offsLow[2:0], 3'b0};
      default: laneShift = 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/ewrf_addr.sv
module ewrf_addr
  import ewrf_pkg::*;
#(
  parameter int ROWS   = 128,
  parameter int ROW_AW = 7,
  parameter int OFFS_W = 10
) (
  input  logic [ROW_AW-1:0] base,
  input  logic [OFFS_W-1:0] offs,
  input  ewSel_e            width,
  output logic [ROW_AW-1:0] row,
  output logic [5:0]        shift,
  output logic              oor
);
  localparam int SUM_W = ((OFFS_W > ROW_AW) ? OFFS_W : ROW_AW) + 1;

  logic [OFFS_W-1:0] rowStep;
  logic [SUM_W-1:0]  rowSum;

  always_comb begin
    rowStep = offs >> width;
    rowSum  = SUM_W'(base) + SUM_W'(rowStep);
    row     = rowSum[ROW_AW-1:0];
    oor     = rowSum > SUM_W'(ROWS - 1);
    shift   = laneShift(width, offs[2:0]);
  end
endmodule

// File: rtl/ewrf_ctrl.sv
module ewrf_ctrl
  import ewrf_pkg::*;
#(
  parameter int ROWS   = 128,
  parameter int ROW_AW = 7,
  parameter int OFFS_W = 10
) (
  input  logic              wrEn,
  input  logic [ROW_AW-1:0] wrBase,
  input  logic [OFFS_W-1:0] wrOffs,
  input  logic [1:0]        wrWidth,
  input  logic [ROW_AW-1:0] rdBase,
  input  logic [OFFS_W-1:0] rdOffs,
  input  logic [1:0]        rdWidth,
  output logic [ROW_AW-1:0] wrRow,
  output logic [ROW_AW-1:0] rdRow,
  output logic              wrOor,
  output logic              rdOor,
  output ctrlStrb_t         strb
);
  ewSel_e     wSel [2];
  logic [5:0] shiftArr [2];
  logic [ROW_AW-1:0] rowArr [2];
  logic       oorArr [2];
  logic [ROW_AW-1:0] baseArr [2];
  logic [OFFS_W-1:0] offsArr [2];

  // port 0 = write, port 1 = read
  assign wSel[0]    = ewSel_e'(wrWidth);
  assign wSel[1]    = ewSel_e'(rdWidth);
  assign baseArr[0] = wrBase;
  assign baseArr[1] = rdBase;
  assign offsArr[0] = wrOffs;
  assign offsArr[1] = rdOffs;

  for (genvar p = 0; p < 2; p++) begin : g_port
    ewrf_addr #(.ROWS(ROWS), .ROW_AW(ROW_AW), .OFFS_W(OFFS_W)) addr_i (
      .base (baseArr[p]),
      .offs (offsArr[p]),
      .width(wSel[p]),
      .row  (rowArr[p]),
      .shift(shiftArr[p]),
      .oor  (oorArr[p])
    );
  end

  always_comb begin
    wrRow         = rowArr[0];
    rdRow         = rowArr[1];
    wrOor         = oorArr[0];
    rdOor         = oorArr[1];
    strb.wrCommit = wrEn && !oorArr[0];
    strb.rdValid  = !oorArr[1];
    strb.fwdHit   = strb.wrCommit && strb.rdValid && (rowArr[0] == rowArr[1]);
    strb.wrFull   = (wSel[0] == EW64);
    strb.rdFull   = (wSel[1] == EW64);
    strb.wrW      = wSel[0];
    strb.rdW      = wSel[1];
    strb.wrShift  = shiftArr[0];
    strb.rdShift  = shiftArr[1];
  end
endmodule

// File: rtl/ewrf_datapath.sv
module ewrf_datapath
  import ewrf_pkg::*;
#(
  parameter int ROWS   = 128,
  parameter int ROW_AW = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ROW_AW-1:0] wrRow,
  input  logic [ROW_AW-1:0] rdRow,
  input  logic [ROW_W-1:0]  wrData,
  output logic [ROW_W-1:0]  rdData
);
  logic [ROW_W-1:0] rowMem [ROWS];
  logic [ROW_W-1:0] wrMask, wrMerged, rdMask, rdSrc;

  // write merge: clear lane, insert width-limited value
  always_comb begin
    wrMask = laneMask(strb.wrW) << strb.wrShift;
    if (strb.wrFull)
      wrMerged = wrData;
    else
      wrMerged = (rowMem[wrRow] & ~wrMask)
               | ((wrData & laneMask(strb.wrW)) << strb.wrShift);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) rowMem[r] <= '0;
    end else if (strb.wrCommit) begin
      rowMem[wrRow] <= wrMerged;
    end
  end

  // read extract with same-cycle forwarding
  always_comb begin
    rdSrc  = strb.fwdHit ? wrMerged : rowMem[rdRow];
    rdMask = laneMask(strb.rdW) << strb.rdShift;
    if (!strb.rdValid)
      rdData = '0;
    else if (strb.rdFull)
      rdData = rdSrc;
    else
      rdData = (rdSrc & rdMask) >> strb.rdShift;
  end
endmodule

// File: rtl/ewRegFile.sv
module ewRegFile
  import ewrf_pkg::*;
#(
  parameter int ROWS   = 128,
  parameter int ROW_AW = $clog2(ROWS),
  parameter int OFFS_W = ROW_AW + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ROW_AW-1:0] wrBase,
  input  logic [OFFS_W-1:0] wrOffs,
  input  logic [1:0]        wrWidth,
  input  logic [63:0]       wrData,
  output logic              wrOor,
  input  logic [ROW_AW-1:0] rdBase,
  input  logic [OFFS_W-1:0] rdOffs,
  input  logic [1:0]        rdWidth,
  output logic [63:0]       rdData,
  output logic              rdOor
);
  ctrlStrb_t         strb;
  logic [ROW_AW-1:0] wrRow, rdRow;

  ewrf_ctrl #(.ROWS(ROWS), .ROW_AW(ROW_AW), .OFFS_W(OFFS_W)) ctrl_i (
    .wrEn(wrEn), .wrBase(wrBase), .wrOffs(wrOffs), .wrWidth(wrWidth),
    .rdBase(rdBase), .rdOffs(rdOffs), .rdWidth(rdWidth),
    .wrRow(wrRow), .rdRow(rdRow), .wrOor(wrOor), .rdOor(rdOor), .strb(strb)
  );

  ewrf_datapath #(.ROWS(ROWS), .ROW_AW(ROW_AW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrRow(wrRow), .rdRow(rdRow),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/ewrf_chk.sv
module ewrf_chk
  import ewrf_pkg::*;
#(
  parameter int ROW_AW = 7,
  parameter int OFFS_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ROW_AW-1:0] wrBase,
  input logic [OFFS_W-1:0] wrOffs,
  input logic [1:0]        wrWidth,
  input logic [63:0]       wrData,
  input logic              wrOor,
  input logic [ROW_AW-1:0] rdBase,
  input logic [OFFS_W-1:0] rdOffs,
  input logic [1:0]        rdWidth,
  input logic [63:0]       rdData,
  input logic              rdOor
);
  a_r8_oor_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdOor |-> rdData == 64'd0);

  a_r4_zero_extend: assert property (@(posedge clk) disable iff (!rstN)
    !rdOor |-> (rdData & ~laneMask(ewSel_e'(rdWidth))) == 64'd0);

  a_r9_forward_same_elem: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrOor && !rdOor && rdBase == wrBase && rdOffs == wrOffs
     && rdWidth == wrWidth)
    |-> rdData == (wrData & laneMask(ewSel_e'(wrWidth))));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && $past(!wrEn) && $stable(rdBase) && $stable(rdOffs)
     && $stable(rdWidth)) |-> $stable(rdData));
endmodule

bind ewRegFile ewrf_chk #(.ROW_AW(ROW_AW), .OFFS_W(OFFS_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBase(wrBase), .wrOffs(wrOffs),
  .wrWidth(wrWidth), .wrData(wrData), .wrOor(wrOor), .rdBase(rdBase),
  .rdOffs(rdOffs), .rdWidth(rdWidth), .rdData(rdData), .rdOor(rdOor)
);

// File: tb/ewRegFile_tb_top.sv
module ewRegFile_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [6:0]  wrBase = '0;
  logic [9:0]  wrOffs = '0;
  logic [1:0]  wrWidth = '0;
  logic [63:0] wrData = '0;
  logic        wrOor;
  logic [6:0]  rdBase = '0;
  logic [9:0]  rdOffs = '0;
  logic [1:0]  rdWidth = '0;
  logic [63:0] rdData;
  logic        rdOor;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  ewRegFile dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBase(wrBase), .wrOffs(wrOffs),
    .wrWidth(wrWidth), .wrData(wrData), .wrOor(wrOor), .rdBase(rdBase),
    .rdOffs(rdOffs), .rdWidth(rdWidth), .rdData(rdData), .rdOor(rdOor)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [6:0] b, input logic [9:0] o,
                         input logic [1:0] w, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrBase = b; wrOffs = o; wrWidth = w; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic readChk(input string req, input logic [6:0] b, input logic [9:0] o,
                         input logic [1:0] w, input logic [63:0] exp);
    @(negedge clk);
    rdBase = b; rdOffs = o; rdWidth = w;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic t_reset;
    readChk("R1 row0", 7'd0, 10'd0, 2'b00, 64'd0);
    readChk("R1 row127", 7'd127, 10'd0, 2'b00, 64'd0);
  endtask

  task automatic t_full;
    doWrite(7'd5, 10'd0, 2'b00, 64'h0123_4567_89AB_CDEF);
    readChk("R2 full row5", 7'd5, 10'd0, 2'b00, 64'h0123_4567_89AB_CDEF);
    readChk("R2 base3 offs2", 7'd3, 10'd2, 2'b00, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_lanes;
    for (int i = 0; i < 8; i++)
      doWrite(7'd10, 10'(i), 2'b11, 64'(8'h11 * (i + 1)));
    readChk("R3 R5 bytes merged", 7'd10, 10'd0, 2'b00, 64'h8877_6655_4433_2211);
    readChk("R4 byte lane3", 7'd10, 10'd3, 2'b11, 64'h44);
    readChk("R3 half lane1", 7'd10, 10'd1, 2'b10, 64'h4433);
    readChk("R3 word lane1", 7'd10, 10'd1, 2'b01, 64'h8877_6655);
  endtask

  task automatic t_preserve;
    doWrite(7'd10, 10'd2, 2'b10, 64'hFFFF_FFFF_FFFF_ABCD);
    readChk("R5 R6 half write", 7'd10, 10'd0, 2'b00, 64'h8877_ABCD_4433_2211);
  endtask

  task automatic t_wrap;
    doWrite(7'd20, 10'd3, 2'b01, 64'hDEAD_BEEF);
    readChk("R7 word wraps to row21", 7'd21, 10'd0, 2'b00, 64'hDEAD_BEEF_0000_0000);
    readChk("R7 row20 untouched", 7'd20, 10'd0, 2'b00, 64'd0);
    doWrite(7'd20, 10'd9, 2'b11, 64'h5A);
    readChk("R7 byte wraps to row21", 7'd21, 10'd0, 2'b00, 64'hDEAD_BEEF_0000_5A00);
  endtask

  task automatic t_oor;
    @(negedge clk);
    wrBase = 7'd127; wrOffs = 10'd8; wrWidth = 2'b11; wrData = 64'hFF;
    rdBase = 7'd127; rdOffs = 10'd8; rdWidth = 2'b11;
    #1;
    check("R8 wrOor set", {63'd0, wrOor}, 64'd1);
    check("R8 rdOor set", {63'd0, rdOor}, 64'd1);
    check("R8 oor read zero", rdData, 64'd0);
    doWrite(7'd127, 10'd8, 2'b11, 64'hFF);
    readChk("R8 row127 unchanged", 7'd127, 10'd0, 2'b00, 64'd0);
    readChk("R8 row0 not aliased", 7'd0, 10'd0, 2'b00, 64'd0);
    @(negedge clk);
    wrBase = 7'd127; wrOffs = 10'd7; wrWidth = 2'b11;
    #1;
    check("R8 last row in range", {63'd0, wrOor}, 64'd0);
    doWrite(7'd127, 10'd7, 2'b11, 64'h9C);
    readChk("R8 last lane written", 7'd127, 10'd0, 2'b00, 64'h9C00_0000_0000_0000);
  endtask

  task automatic t_forward;
    doWrite(7'd30, 10'd0, 2'b00, 64'h1111_1111_1111_1111);
    @(negedge clk);
    wrEn = 1'b1; wrBase = 7'd30; wrOffs = 10'd0; wrWidth = 2'b11; wrData = 64'hAB;
    rdBase = 7'd30; rdOffs = 10'd0; rdWidth = 2'b00;
    #1;
    check("R9 forwarded merge", rdData, 64'h1111_1111_1111_11AB);
    @(posedge clk); #1;
    wrEn = 1'b0;
    readChk("R9 after commit", 7'd30, 10'd0, 2'b00, 64'h1111_1111_1111_11AB);
  endtask

  task automatic t_noWrite;
    @(negedge clk);
    wrEn = 1'b0; wrBase = 7'd30; wrOffs = 10'd0; wrWidth = 2'b00; wrData = 64'hFFFF;
    @(posedge clk); #1;
    readChk("R10 disabled write", 7'd30, 10'd0, 2'b00, 64'h1111_1111_1111_11AB);
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_full();
    t_lanes();
    t_preserve();
    t_wrap();
    t_oor();
    t_forward();
    t_noWrite();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule